// File: doc/BRIEF.md
# Clock Source Selector with Two-Phase Clock Generator

This block chooses the source that paces the system and peripheral clock and turns it into a pair of non-overlapping phases. Four sources are possible: the main oscillator halved, the main oscillator at full rate, the 32 kHz-class sub oscillator, and the synthesizer output. Each source enters as a one-cycle enable strobe on a fast reference clock, so all logic runs in a single clock domain. The block halves the selected source. Phase one is high during one source period and phase two during the next, with a dead time of one reference cycle between them.

A 2-bit mode field owned by another register enters as an input. It works together with a local 8-bit control register on a simple address/write-enable bus. The local register holds a full-rate select bit and two oscillator-drive disable bits, which leave the block as plain control outputs. A change of source is applied only at the end of a phase-two pulse. The generator then idles with both phases low until the new source strobes, so no phase pulse is ever cut short.

Top module: `sysclk_twophase`

## Requirements
- R1: The control register answers at bus address 0x1F, is readable and writable, and reads 0x00 after reset. Any other address reads 0x00.
- R2: Bits 4..0 of the control register always read 0, whatever was written. A write to any address other than 0x1F changes nothing.
- R3: Register bit 5 drives `sub_drv_off` and bit 6 drives `main_drv_off`, one reference cycle after the write edge. Both are 0 after reset.
- R4: Source decode: `mode_sel` 01 selects the sub strobe and 11 selects the synthesizer strobe. For 00 or 10, register bit 7 = 0 selects every second main strobe and bit 7 = 1 selects every main strobe.
- R5: Phases alternate, phase one then phase two. Each phase rises one reference cycle after a strobe of the active source. It stays high until the edge that samples the next strobe, so its high time is the source period minus one reference cycle.
- R6: `phi1` and `phi2` are never high together. At least one reference cycle with both low separates one phase falling from the other rising.
- R7: After reset the source is the main oscillator halved, and the first pulse is on `phi1`.
- R8: A new selection takes effect only when a `phi2` pulse ends. The generator then keeps both phases low until a strobe of the new source, and no phase pulse is shorter than one source period minus one reference cycle.
- R9: Strobes of sources that are not selected have no effect on the phases.
- R10: Source strobes must be at least two reference cycles apart. A strobe that arrives in the dead cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Register bus address |
| bus_we | input | 1 | Register write enable |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data (combinational) |
| mode_sel | input | 2 | Clock mode field from another register |
| main_tick | input | 1 | Main oscillator strobe |
| sub_tick | input | 1 | Sub oscillator strobe |
| syn_tick | input | 1 | Synthesizer strobe |
| main_drv_off | output | 1 | Main oscillator output-drive disable |
| sub_drv_off | output | 1 | Sub oscillator output-drive disable |
| phi1 | output | 1 | System clock phase one |
| phi2 | output | 1 | System clock phase two |

## Verification
The two functions that can meet in one cycle are a register write that changes the source and the strobe that ends a `phi2` pulse at the switch point. The bench provokes this by toggling the full-rate bit at every offset within several source periods. This moves the write before, onto and after the closing strobe. Each case is judged by watching every phase pulse at the pins: it must keep its minimum width, the phases must keep alternating, and the dead gap must hold. Steady-state runs then compare the pulse widths against a scoreboard of expected values.

// File: rtl/sysclk_pkg.sv
package sysclk_pkg;
  localparam int NUM_SRC = 4;

  typedef enum logic [1:0] {
    SRC_MAIN_HALF = 2'd0,
    SRC_MAIN_FULL = 2'd1,
    SRC_SUB       = 2'd2,
    SRC_SYN       = 2'd3
  } src_e;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_LEAD1 = 3'd1,
    PH_ONE   = 3'd2,
    PH_LEAD2 = 3'd3,
    PH_TWO   = 3'd4
  } ph_e;
endpackage

// File: rtl/sysclk_ctrl_reg.sv
module sysclk_ctrl_reg #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int LOW_RSVD = 5,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 'h1F,
  localparam int KEEP_W = DATA_W - LOW_RSVD
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [KEEP_W-1:0] ctrl_bits
);
  logic hit;
  assign hit = (bus_addr == CTRL_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      ctrl_bits <= '0;
    else if (bus_we && hit)
      ctrl_bits <= bus_wdata[DATA_W-1:LOW_RSVD];
  end

  assign bus_rdata = hit ? {ctrl_bits, {LOW_RSVD{1'b0}}} : '0;
endmodule

// File: rtl/sysclk_src_select.sv
module sysclk_src_select
  import sysclk_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         mode_sel,
  input  logic               full_rate,
  input  logic               main_tick,
  input  logic               sub_tick,
  input  logic               syn_tick,
  output src_e               req_src,
  output logic [NUM_SRC-1:0] tick_vec
);
  logic half_tgl;

  // Divide the main strobe by two: pass every second strobe.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      half_tgl <= 1'b0;
    else if (main_tick)
      half_tgl <= ~half_tgl;
  end

  assign tick_vec[SRC_MAIN_HALF] = main_tick & half_tgl;
  assign tick_vec[SRC_MAIN_FULL] = main_tick;
  assign tick_vec[SRC_SUB]       = sub_tick;
  assign tick_vec[SRC_SYN]       = syn_tick;

  always_comb begin
    unique case (mode_sel)
      2'b01:   req_src = SRC_SUB;
      2'b11:   req_src = SRC_SYN;
      default: req_src = full_rate ? SRC_MAIN_FULL : SRC_MAIN_HALF;
    endcase
  end
endmodule

// File: rtl/sysclk_phase_fsm.sv
module sysclk_phase_fsm
  import sysclk_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  src_e               req_src,
  input  logic [NUM_SRC-1:0] tick_vec,
  output logic               phi1,
  output logic               phi2
);
  ph_e  state, state_nx;
  src_e cur_src, cur_nx;
  logic cur_tick, req_tick;

  assign cur_tick = tick_vec[cur_src];
  assign req_tick = tick_vec[req_src];

  always_comb begin
    state_nx = state;
    cur_nx   = cur_src;
    unique case (state)
      PH_IDLE: begin
        cur_nx = req_src;
        if (req_tick) state_nx = PH_LEAD1;
      end
      PH_LEAD1: state_nx = PH_ONE;
      PH_ONE:   if (cur_tick) state_nx = PH_LEAD2;
      PH_LEAD2: state_nx = PH_TWO;
      PH_TWO: begin
        // Switch point: both phases drop here.
        if (cur_tick) state_nx = (req_src != cur_src) ? PH_IDLE : PH_LEAD1;
      end
      default:  state_nx = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= PH_IDLE;
      cur_src <= SRC_MAIN_HALF;
      phi1    <= 1'b0;
      phi2    <= 1'b0;
    end else begin
      state   <= state_nx;
      cur_src <= cur_nx;
      phi1    <= (state_nx == PH_ONE);
      phi2    <= (state_nx == PH_TWO);
    end
  end
endmodule

// File: rtl/sysclk_twophase.sv
module sysclk_twophase
  import sysclk_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 'h1F,
  parameter int FULL_BIT = 7,
  parameter int MAIN_OFF_BIT = 6,
  parameter int SUB_OFF_BIT = 5,
  localparam int LOW_RSVD = SUB_OFF_BIT,
  localparam int KEEP_W = DATA_W - LOW_RSVD
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [1:0]        mode_sel,
  input  logic              main_tick,
  input  logic              sub_tick,
  input  logic              syn_tick,
  output logic              main_drv_off,
  output logic              sub_drv_off,
  output logic              phi1,
  output logic              phi2
);
  logic [KEEP_W-1:0]  ctrl_bits;
  src_e               req_src;
  logic [NUM_SRC-1:0] tick_vec;

  sysclk_ctrl_reg #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LOW_RSVD(LOW_RSVD), .CTRL_ADDR(CTRL_ADDR)
  ) u_reg (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ctrl_bits(ctrl_bits)
  );

  assign sub_drv_off  = ctrl_bits[SUB_OFF_BIT - LOW_RSVD];
  assign main_drv_off = ctrl_bits[MAIN_OFF_BIT - LOW_RSVD];

  sysclk_src_select u_sel (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel),
    .full_rate(ctrl_bits[FULL_BIT - LOW_RSVD]),
    .main_tick(main_tick), .sub_tick(sub_tick), .syn_tick(syn_tick),
    .req_src(req_src), .tick_vec(tick_vec)
  );

  sysclk_phase_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .req_src(req_src), .tick_vec(tick_vec),
    .phi1(phi1), .phi2(phi2)
  );
endmodule

// File: rtl/sysclk_twophase_chk.sv
module sysclk_twophase_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] bus_addr,
  input logic       bus_we,
  input logic [7:0] bus_wdata,
  input logic [7:0] bus_rdata,
  input logic       main_drv_off,
  input logic       sub_drv_off,
  input logic       phi1,
  input logic       phi2
);
  logic last_one;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     last_one <= 1'b0;
    else if (phi1)  last_one <= 1'b1;
    else if (phi2)  last_one <= 1'b0;
  end

  a_r6_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(phi1 && phi2));

  a_r6_gap_before_phi2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(phi2) |-> !$past(phi1));

  a_r6_gap_before_phi1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(phi1) |-> !$past(phi2));

  a_r5_phi1_after_phi2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(phi1) |-> !last_one);

  a_r5_phi2_after_phi1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(phi2) |-> last_one);

  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[4:0] == 5'd0);

  a_r3_drive_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 8'h1F) |=>
      (main_drv_off == $past(bus_wdata[6]) && sub_drv_off == $past(bus_wdata[5])));

  a_r2_other_addr_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && bus_addr == 8'h1F) |=> ($stable(main_drv_off) && $stable(sub_drv_off)));
endmodule

bind sysclk_twophase sysclk_twophase_chk u_chk (.*);

// File: tb/sim_sysclk_twophase.sv
`timescale 1ns/1ps
module sim_sysclk_twophase;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] bus_addr = 8'h00;
  logic       bus_we = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic [1:0] mode_sel = 2'b00;
  logic       main_tick = 1'b0, sub_tick = 1'b0, syn_tick = 1'b0;
  logic       main_drv_off, sub_drv_off, phi1, phi2;

  localparam int MAIN_P = 3, SUB_P = 7, SYN_P = 4;

  always #5 clk = ~clk;

  sysclk_twophase u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mode_sel(mode_sel),
    .main_tick(main_tick), .sub_tick(sub_tick), .syn_tick(syn_tick),
    .main_drv_off(main_drv_off), .sub_drv_off(sub_drv_off),
    .phi1(phi1), .phi2(phi2)
  );

  int tests = 0, fails = 0;

  // Source strobe generators, each with its own period.
  int cm = 0, cs = 0, cy = 0;
  always @(negedge clk) begin
    cm = (cm + 1) % MAIN_P; cs = (cs + 1) % SUB_P; cy = (cy + 1) % SYN_P;
    main_tick <= (cm == 0);
    sub_tick  <= (cs == 0);
    syn_tick  <= (cy == 0);
  end

  typedef struct { int ph; int w; string tag; } exp_t;
  exp_t sb[$];
  bit scoring = 1'b0;
  int w1 = 0, w2 = 0, low_run = 0, last_ph = 0, short_cnt = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic on_rise(input int ph);
    check(last_ph != ph, "R5 alternation", ph, 3 - ph);
    check(low_run >= 1, "R6 dead gap", low_run, 1);
    last_ph = ph;
    low_run = 0;
  endtask

  task automatic on_fall(input int ph, input int w);
    exp_t e;
    if (w < 2) short_cnt++;
    if (scoring && sb.size() > 0) begin
      e = sb.pop_front();
      if (e.ph != 0) check(ph == e.ph, {e.tag, " phase"}, ph, e.ph);
      check(w == e.w, {e.tag, " width"}, w, e.w);
    end
  endtask

  // Monitor: measures every phase pulse at the pins.
  always @(negedge clk) begin
    if (!rst_n) begin
      w1 = 0; w2 = 0; low_run = 1; last_ph = 2;
    end else begin
      if (phi1 && phi2) check(1'b0, "R6 overlap", 1, 0);
      if (phi1) begin
        if (w1 == 0) on_rise(1);
        w1++;
      end else if (w1 > 0) begin
        on_fall(1, w1); w1 = 0;
      end
      if (phi2) begin
        if (w2 == 0) on_rise(2);
        w2++;
      end else if (w2 > 0) begin
        on_fall(2, w2); w2 = 0;
      end
      if (!phi1 && !phi2) low_run++;
    end
  end

  task automatic push(input int ph, input int w, input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      exp_t e;
      e.ph = (i == 0) ? ph : 0; e.w = w; e.tag = tag;
      sb.push_back(e);
    end
  endtask

  task automatic run_scored(input int w, input int n, input string tag);
    push(0, w, n, tag);
    scoring = 1'b1;
    while (sb.size() > 0) @(negedge clk);
    scoring = 1'b0;
  endtask

  task automatic settle();
    repeat (50) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; bus_addr = 8'h1F;
  endtask

  task automatic rd_check(input logic [7:0] a, input logic [7:0] exp, input string tag);
    bus_addr = a;
    #1;
    check(bus_rdata == exp, tag, bus_rdata, exp);
    bus_addr = 8'h1F;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    bus_addr = 8'h1F;
    // R7: first pulse after reset is phi1 at main/2 (2*3-1 = 5 cycles).
    push(1, 5, 4, "R7 reset default main/2");
    scoring = 1'b1;
    repeat (3) @(negedge clk);
    // R1 / R3 reset state.
    rd_check(8'h1F, 8'h00, "R1 reset read");
    check(!main_drv_off && !sub_drv_off, "R3 reset drive bits", {main_drv_off, sub_drv_off}, 0);
    check(!phi1 && !phi2, "R6 phases low in reset", {phi1, phi2}, 0);
    rst_n = 1'b1;
    while (sb.size() > 0) @(negedge clk);
    scoring = 1'b0;

    // R4: mode 00 with full-rate bit -> every main strobe.
    wr(8'h1F, 8'h80); settle();
    run_scored(MAIN_P - 1, 4, "R4 mode00 full");
    mode_sel = 2'b10; settle();
    run_scored(MAIN_P - 1, 4, "R4 mode10 full");
    wr(8'h1F, 8'h00); settle();
    run_scored(2 * MAIN_P - 1, 4, "R4 mode10 half");
    // R9: other strobes keep running but only the selected one counts.
    mode_sel = 2'b01; settle();
    run_scored(SUB_P - 1, 4, "R9 R4 mode01 sub");
    wr(8'h1F, 8'h80); settle();
    run_scored(SUB_P - 1, 3, "R9 full bit ignored in sub mode");
    mode_sel = 2'b11; settle();
    run_scored(SYN_P - 1, 4, "R9 R4 mode11 synth");

    // R1 / R2 / R3: register behaviour at the bus.
    wr(8'h1F, 8'hFF);
    rd_check(8'h1F, 8'hE0, "R2 reserved bits read 0");
    check(main_drv_off && sub_drv_off, "R3 drive bits set", {main_drv_off, sub_drv_off}, 3);
    wr(8'h1E, 8'h00);
    rd_check(8'h1F, 8'hE0, "R2 other address ignored");
    check(main_drv_off && sub_drv_off, "R2 drive bits kept", {main_drv_off, sub_drv_off}, 3);
    rd_check(8'h1E, 8'h00, "R1 other address reads 0");
    wr(8'h1F, 8'h20);
    check(!main_drv_off && sub_drv_off, "R3 bit5 only", {main_drv_off, sub_drv_off}, 1);
    wr(8'h1F, 8'h40);
    check(main_drv_off && !sub_drv_off, "R3 bit6 only", {main_drv_off, sub_drv_off}, 2);
    rd_check(8'h1F, 8'h40, "R1 read back");

    // R8: switch at every offset relative to the phase pattern.
    mode_sel = 2'b00;
    for (int k = 0; k < 12; k++) begin
      repeat (k) @(negedge clk);
      wr(8'h1F, (k % 2) ? 8'h00 : 8'h80);
      repeat (9) @(negedge clk);
    end
    wr(8'h1F, 8'h00); settle();
    run_scored(2 * MAIN_P - 1, 4, "R8 steady after switching");
    for (int k = 0; k < 8; k++) begin
      repeat (k + 1) @(negedge clk);
      mode_sel = (k % 2) ? 2'b01 : 2'b11;
      repeat (5) @(negedge clk);
    end
    mode_sel = 2'b11; settle();
    run_scored(SYN_P - 1, 4, "R8 R10 steady synth after switching");
    check(short_cnt == 0, "R8 no short pulse", short_cnt, 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule